// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit buffer descriptors held in system memory. Software programs the ring base address, enables the controller and pulses the activate strobe. The walker then fetches descriptors one after another over a simple request/acknowledge memory port. It stops at the first descriptor that software has not marked ready. For each ready descriptor it reads the buffer it points to and streams the bytes out one per cycle. It then hands the descriptor back by writing it to memory with the ready bit cleared, and moves to the next slot.

A descriptor occupies 8 bytes. The first word holds a 16-bit byte count in bits [15:0] and the control flags in the upper half: ready in bit 31, wrap in bit 29 and last-of-frame in bit 27. The second word, at offset 4, holds the buffer byte address. A frame may span several descriptors, and its end is marked on the descriptor that carries the last flag. Frames longer than a parameterised maximum are cut short and flagged. One activation consumes at most a parameterised number of descriptors.

The controller is a single state machine with these states: IDLE, HDR (read the flag/length word), BUFPTR (read the buffer address), LOAD (read one buffer word), EMIT (send one byte) and WBACK (write the descriptor back). Its transitions are:
- IDLE to HDR on an accepted activate.
- HDR to BUFPTR when the fetched descriptor is ready, and HDR to IDLE when it is not.
- BUFPTR to LOAD when bytes remain to send, and BUFPTR to WBACK when none do.
- LOAD to EMIT once the word arrives.
- EMIT to itself while the current word still has bytes, EMIT to LOAD at a word boundary, and EMIT to WBACK after the final byte.
- WBACK to HDR after the write is acknowledged, or WBACK to IDLE when the per-activation cap is reached.

Top module: `tdr_engine`

## Requirements
- R1: A one-cycle `kick` while `ctrl_en` is high and the walker is idle starts a walk: `active` rises and the first descriptor read is issued at the current descriptor pointer. The walk ends at the first descriptor whose bit 31 (ready) is 0, after which `active` reads 0. After reset, `active`, `mem_req`, `tx_valid` and all interrupt pulses are 0.
- R2: One activation consumes at most MAX_DESC descriptors. The next activation continues from the following slot.
- R3: Buffer bytes leave on `tx_data` with `tx_valid` high, one per cycle, starting at the buffer byte address in word 1 and ascending. Within each 32-bit memory word, byte lane n (bits 8n+7:8n) holds the byte at address offset n.
- R4: If the running frame length plus the descriptor's byte count exceeds MAX_FRAME, only the remaining allowance is sent and `irq_babt` pulses for that descriptor. No frame reported on `tx_len` exceeds MAX_FRAME.
- R5: On a descriptor with bit 27 (last) set, `tx_eof` pulses with the frame's byte count on `tx_len`, `irq_txf` pulses, and the running frame length restarts at zero. It also restarts at zero at each activation.
- R6: Every consumed descriptor is written back to its own address with bit 31 cleared and all other bits unchanged, and `irq_txb` pulses once for it.
- R7: After a descriptor with bit 29 (wrap) set, the next descriptor address is the ring base. Otherwise it is the current address plus 8.
- R8: The descriptor pointer persists between activations. While the controller is disabled and idle, the pointer reloads from the ring base.
- R9: `kick` has no effect while `ctrl_en` is low or while a walk is in progress.
- R10: A ring base write clears address bits [1:0] when `ext_align` is 0 and bits [2:0] when it is 1, and it also loads the descriptor pointer.
- R11: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`. Read data is taken in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable |
| ext_align | input | 1 | Selects 8-byte ring base alignment (else 4-byte) |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | 32 | Ring base write value |
| kick | input | 1 | Transmit activate strobe |
| active | output | 1 | Activate bit; high while a walk runs |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_eof | output | 1 | End-of-frame pulse |
| tx_len | output | 16 | Frame byte count, valid with tx_eof |
| irq_txb | output | 1 | Descriptor consumed pulse |
| irq_txf | output | 1 | Frame completed pulse |
| irq_babt | output | 1 | Oversize truncation pulse |

## Verification
Every result has a fixed delay. An accepted `kick` shows the first descriptor request right after the sampling edge. Each byte appears on `tx_data` one cycle after the walker enters EMIT. The `irq_txb`, `irq_txf`, `tx_eof` and `irq_babt` pulses come one cycle after the acknowledge that completes the write-back or the buffer-address read. The bench samples every output at the falling edge and checks the first request address in the cycle after the kick. Each streamed byte and frame length is compared against queues filled by a behavioural walk of the bench's own memory image. Pulse counts and the written-back descriptors are compared two cycles after `active` falls, by which point every pulse of the walk has been emitted.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned RDY_BIT    = 31;
    localparam int unsigned WRAP_BIT   = 29;
    localparam int unsigned LAST_BIT   = 27;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_BUFPTR,
        ST_LOAD,
        ST_EMIT,
        ST_WBACK
    } walk_state_t;

endpackage

// File: rtl/tdr_ring_ptr.sv
module tdr_ring_ptr
    import tdr_pkg::*;
#(
    parameter int unsigned MAX_DESC = 1024
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              ext_align,
    input  logic              base_wr,
    input  logic [WORD_W-1:0] base_wdata,
    input  logic              idle,
    input  logic              start,
    input  logic              adv,
    input  logic              adv_wrap,
    output logic [WORD_W-1:0] cur_ptr,
    output logic              last_slot
);

    localparam int unsigned CNT_W = $clog2(MAX_DESC + 1);

    logic [WORD_W-1:0] base_q;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] base_aligned;
    logic [CNT_W-1:0]  used_q;

    assign mask         = ext_align ? WORD_W'(7) : WORD_W'(3);
    assign base_aligned = base_wdata & ~mask;
    assign last_slot    = (used_q == CNT_W'(MAX_DESC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            cur_ptr <= '0;
            used_q  <= '0;
        end else begin
            if (base_wr) begin
                base_q <= base_aligned;
            end

            if (idle && base_wr) begin
                cur_ptr <= base_aligned;
            end else if (idle && !ctrl_en) begin
                cur_ptr <= base_q;
            end else if (adv) begin
                cur_ptr <= adv_wrap ? base_q : cur_ptr + WORD_W'(DESC_BYTES);
            end

            if (start) begin
                used_q <= '0;
            end else if (adv) begin
                used_q <= used_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdr_len_clamp.sv
module tdr_len_clamp #(
    parameter int unsigned MAX_FRAME = 2047,
    parameter int unsigned FLW       = 11
)
(
    input  logic [FLW-1:0] frame_len,
    input  logic [15:0]    buf_len,
    output logic [15:0]    send_len,
    output logic           babble
);

    logic [31:0] room;

    assign room     = 32'(MAX_FRAME) - 32'(frame_len);
    assign babble   = 32'(buf_len) > room;
    assign send_len = babble ? room[15:0] : buf_len;

endmodule

// File: rtl/tdr_walker.sv
module tdr_walker
    import tdr_pkg::*;
#(
    parameter int unsigned FLW = 11
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              ctrl_en,
    input  logic [WORD_W-1:0] cur_ptr,
    input  logic              last_slot,
    output logic              start,
    output logic              adv,
    output logic              adv_wrap,
    output logic              idle,
    output logic [FLW-1:0]    frame_len,
    output logic [15:0]       hdr_len,
    input  logic [15:0]       send_len,
    input  logic              babble,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              active,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_eof,
    output logic [15:0]       tx_len,
    output logic              irq_txb,
    output logic              irq_txf,
    output logic              irq_babt
);

    walk_state_t       state, nxt;
    logic [WORD_W-1:0] hdr_word;
    logic [WORD_W-1:0] buf_ptr;
    logic [WORD_W-1:0] data_word;
    logic [15:0]       remain;

    assign idle     = (state == ST_IDLE);
    assign start    = idle && kick && ctrl_en;
    assign adv      = (state == ST_WBACK) && mem_ack;
    assign adv_wrap = hdr_word[WRAP_BIT];
    assign hdr_len  = hdr_word[15:0];

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_HDR;
            ST_HDR:    if (mem_ack) nxt = mem_rdata[RDY_BIT] ? ST_BUFPTR : ST_IDLE;
            ST_BUFPTR: if (mem_ack) nxt = (send_len == 16'd0) ? ST_WBACK : ST_LOAD;
            ST_LOAD:   if (mem_ack) nxt = ST_EMIT;
            ST_EMIT: begin
                if (remain == 16'd1)            nxt = ST_WBACK;
                else if (buf_ptr[1:0] == 2'b11) nxt = ST_LOAD;
                else                            nxt = ST_EMIT;
            end
            ST_WBACK:  if (mem_ack) nxt = last_slot ? ST_IDLE : ST_HDR;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // memory port, driven from the state alone
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr;
            end
            ST_BUFPTR: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + WORD_W'(4);
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = {buf_ptr[WORD_W-1:2], 2'b00};
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr;
                mem_wdata = hdr_word & ~(WORD_W'(1) << RDY_BIT);
            end
            default: ;
        endcase
    end

    // datapath and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active    <= 1'b0;
            hdr_word  <= '0;
            buf_ptr   <= '0;
            data_word <= '0;
            remain    <= '0;
            frame_len <= '0;
            tx_valid  <= 1'b0;
            tx_data   <= '0;
            tx_eof    <= 1'b0;
            tx_len    <= '0;
            irq_txb   <= 1'b0;
            irq_txf   <= 1'b0;
            irq_babt  <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_eof   <= 1'b0;
            irq_txb  <= 1'b0;
            irq_txf  <= 1'b0;
            irq_babt <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        active    <= 1'b1;
                        frame_len <= '0;
                    end
                end
                ST_HDR: begin
                    if (mem_ack) begin
                        hdr_word <= mem_rdata;
                        if (!mem_rdata[RDY_BIT]) active <= 1'b0;
                    end
                end
                ST_BUFPTR: begin
                    if (mem_ack) begin
                        buf_ptr  <= mem_rdata;
                        remain   <= send_len;
                        irq_babt <= babble;
                    end
                end
                ST_LOAD: begin
                    if (mem_ack) data_word <= mem_rdata;
                end
                ST_EMIT: begin
                    tx_valid  <= 1'b1;
                    tx_data   <= data_word[{buf_ptr[1:0], 3'b000} +: 8];
                    buf_ptr   <= buf_ptr + 1'b1;
                    remain    <= remain - 1'b1;
                    frame_len <= frame_len + 1'b1;
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        irq_txb <= 1'b1;
                        if (hdr_word[LAST_BIT]) begin
                            tx_eof    <= 1'b1;
                            tx_len    <= 16'(frame_len);
                            irq_txf   <= 1'b1;
                            frame_len <= '0;
                        end
                        if (last_slot) active <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
    import tdr_pkg::*;
#(
    parameter int unsigned MAX_FRAME = 2047,
    parameter int unsigned MAX_DESC  = 1024
)
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_en,
    input  logic        ext_align,
    input  logic        base_wr,
    input  logic [31:0] base_wdata,
    input  logic        kick,
    output logic        active,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_eof,
    output logic [15:0] tx_len,
    output logic        irq_txb,
    output logic        irq_txf,
    output logic        irq_babt
);

    localparam int unsigned FLW = $clog2(MAX_FRAME + 1);

    logic [WORD_W-1:0] cur_ptr;
    logic              last_slot;
    logic              start;
    logic              adv;
    logic              adv_wrap;
    logic              idle;
    logic [FLW-1:0]    frame_len;
    logic [15:0]       hdr_len;
    logic [15:0]       send_len;
    logic              babble;

    tdr_ring_ptr #(.MAX_DESC(MAX_DESC)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_en    (ctrl_en),
        .ext_align  (ext_align),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .idle       (idle),
        .start      (start),
        .adv        (adv),
        .adv_wrap   (adv_wrap),
        .cur_ptr    (cur_ptr),
        .last_slot  (last_slot)
    );

    tdr_len_clamp #(.MAX_FRAME(MAX_FRAME), .FLW(FLW)) u_clamp (
        .frame_len (frame_len),
        .buf_len   (hdr_len),
        .send_len  (send_len),
        .babble    (babble)
    );

    tdr_walker #(.FLW(FLW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .ctrl_en   (ctrl_en),
        .cur_ptr   (cur_ptr),
        .last_slot (last_slot),
        .start     (start),
        .adv       (adv),
        .adv_wrap  (adv_wrap),
        .idle      (idle),
        .frame_len (frame_len),
        .hdr_len   (hdr_len),
        .send_len  (send_len),
        .babble    (babble),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .active    (active),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_eof    (tx_eof),
        .tx_len    (tx_len),
        .irq_txb   (irq_txb),
        .irq_txf   (irq_txf),
        .irq_babt  (irq_babt)
    );

endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk #(
    parameter int unsigned MAX_FRAME = 2047
)
(
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_en,
    input logic        kick,
    input logic        active,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        wb_ready,
    input logic        tx_valid,
    input logic        tx_eof,
    input logic [15:0] tx_len,
    input logic        irq_txb,
    input logic        irq_txf
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req && !tx_valid); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |-> tx_len <= 16'(MAX_FRAME)); // R4

    AST_EOF_FRAME_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |-> irq_txf); // R5

    AST_FRAME_HAS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txf |-> irq_txb); // R6

    AST_WB_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !wb_ready); // R6

    AST_KICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        kick && !ctrl_en && !active |=> !active); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

endmodule

bind tdr_engine tdr_engine_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_en  (ctrl_en),
    .kick     (kick),
    .active   (active),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .wb_ready (mem_wdata[31]),
    .tx_valid (tx_valid),
    .tx_eof   (tx_eof),
    .tx_len   (tx_len),
    .irq_txb  (irq_txb),
    .irq_txf  (irq_txf)
);

// File: tb/tdr_engine_tb.sv
module tdr_engine_tb;

    localparam int unsigned MAXF = 64;
    localparam int unsigned MAXD = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en, ext_align, base_wr, kick;
    logic [31:0] base_wdata;
    logic        active, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_eof, irq_txb, irq_txf, irq_babt;
    logic [7:0]  tx_data;
    logic [15:0] tx_len;

    always #4 clk = ~clk;

    tdr_engine #(.MAX_FRAME(MAXF), .MAX_DESC(MAXD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ext_align(ext_align),
        .base_wr(base_wr), .base_wdata(base_wdata), .kick(kick), .active(active),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_eof(tx_eof), .tx_len(tx_len), .irq_txb(irq_txb), .irq_txf(irq_txf),
        .irq_babt(irq_babt)
    );

    // memory image, word addressed
    logic [31:0] mem    [int unsigned];
    logic [31:0] shadow [int unsigned];

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;

    logic [7:0] exp_bytes[$];
    int         exp_lens[$];
    int exp_txb, exp_txf, exp_babt;
    int cnt_txb, cnt_txf, cnt_babt;
    int unsigned m_base, m_ptr, m_next;

    function automatic logic [31:0] rdm(input int unsigned k);
        return mem.exists(k) ? mem[k] : 32'h0;
    endfunction

    function automatic logic [31:0] rds(input int unsigned k);
        return shadow.exists(k) ? shadow[k] : 32'h0;
    endfunction

    function automatic logic [7:0] byte_at(input int unsigned a);
        logic [31:0] w;
        w = rdm(a >> 2);
        return w[(a % 4) * 8 +: 8];
    endfunction

    function automatic logic [7:0] pat(input int unsigned a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    task automatic set_byte(input int unsigned a, input logic [7:0] v);
        logic [31:0] w;
        w = rdm(a >> 2);
        w[(a % 4) * 8 +: 8] = v;
        mem[a >> 2] = w;
    endtask

    task automatic set_desc(input int unsigned p, input int len, input bit rdy,
                            input bit wrp, input bit lst, input int unsigned bufa);
        mem[p >> 2]       = {rdy, 1'b0, wrp, 1'b0, lst, 11'd0, 16'(len)};
        mem[(p + 4) >> 2] = bufa;
        for (int i = 0; i < len; i++) set_byte(bufa + i, pat(bufa + i));
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr >> 2] = mem_wdata;
            else        mem_rdata <= rdm(mem_addr >> 2);
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // output monitor against the model queues
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (tx_valid) begin
                if (exp_bytes.size() == 0) chk(1'b0, "R3", "unexpected byte", 32'(tx_data), 32'h0);
                else begin
                    logic [7:0] e;
                    e = exp_bytes.pop_front();
                    chk(tx_data == e, "R3", "stream byte", 32'(tx_data), 32'(e));
                end
            end
            if (tx_eof) begin
                if (exp_lens.size() == 0) chk(1'b0, "R5", "unexpected frame end", 32'(tx_len), 32'h0);
                else begin
                    int e;
                    e = exp_lens.pop_front();
                    chk(32'(tx_len) == 32'(e), "R5", "frame length", 32'(tx_len), 32'(e));
                end
            end
            if (irq_txb)  cnt_txb++;
            if (irq_txf)  cnt_txf++;
            if (irq_babt) cnt_babt++;
        end
    end

    // behavioural walk of the ring
    task automatic predict();
        int unsigned p, bufa, len, room, snd;
        int n, fl;
        logic [31:0] h;
        shadow = mem;
        exp_txb = 0; exp_txf = 0; exp_babt = 0;
        p = m_ptr; n = 0; fl = 0;
        while (n < MAXD) begin
            h = rds(p >> 2);
            if (!h[31]) break;
            len  = h[15:0];
            bufa = rds((p + 4) >> 2);
            room = MAXF - fl;
            if (len > room) begin snd = room; exp_babt++; end
            else snd = len;
            for (int i = 0; i < int'(snd); i++) exp_bytes.push_back(byte_at(bufa + i));
            fl += snd;
            if (h[27]) begin exp_lens.push_back(fl); fl = 0; exp_txf++; end
            exp_txb++;
            shadow[p >> 2] = h & 32'h7fff_ffff;
            p = h[29] ? m_base : p + 8;
            n++;
        end
        m_next = p;
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = v;
        @(negedge clk);
        base_wr = 1'b0;
        m_base = v & ~(ext_align ? 32'h7 : 32'h3);
        m_ptr  = m_base;
    endtask

    task automatic run_walk(input string tag, input bit rekick);
        int guard, mism;
        predict();
        cnt_txb = 0; cnt_txf = 0; cnt_babt = 0;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        // R1 R8 R10: first fetch issued at the pointer the model holds
        chk(mem_req && !mem_we && mem_addr == m_ptr, "R1",
            $sformatf("%s first fetch address", tag), mem_addr, m_ptr);
        chk(active, "R1", $sformatf("%s activate bit set", tag), 32'(active), 32'h1);
        if (rekick) begin
            repeat (20) @(negedge clk);
            kick = 1'b1;                 // R9: ignored mid-walk
            @(negedge clk); kick = 1'b0;
        end
        guard = 0;
        while (active && guard < 20000) begin @(negedge clk); guard++; end
        repeat (2) @(negedge clk);
        chk(!active, "R1", $sformatf("%s activate reads zero", tag), 32'(active), 32'h0);
        chk(exp_bytes.size() == 0, "R3", $sformatf("%s bytes missing", tag),
            32'(exp_bytes.size()), 32'h0);
        chk(exp_lens.size() == 0, "R5", $sformatf("%s frames missing", tag),
            32'(exp_lens.size()), 32'h0);
        chk(cnt_txb == exp_txb, "R6", $sformatf("%s buffer pulses (R2 cap)", tag),
            32'(cnt_txb), 32'(exp_txb));
        chk(cnt_txf == exp_txf, "R5", $sformatf("%s frame pulses", tag),
            32'(cnt_txf), 32'(exp_txf));
        chk(cnt_babt == exp_babt, "R4", $sformatf("%s babble pulses", tag),
            32'(cnt_babt), 32'(exp_babt));
        mism = 0;
        foreach (shadow[k]) if (rdm(k) !== shadow[k]) mism++;
        chk(mism == 0, "R6", $sformatf("%s descriptors written back", tag), 32'(mism), 32'h0);
        exp_bytes.delete();
        exp_lens.delete();
        m_ptr = m_next;
    endtask

    task automatic disabled_kick();
        @(negedge clk); ctrl_en = 1'b0;
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!active && !mem_req, "R9", "kick while disabled",
                {30'd0, active, mem_req}, 32'h0);
            @(negedge clk);
        end
        ctrl_en = 1'b1;
        m_ptr = m_base;                  // R8: disable reloads the pointer
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        ctrl_en = 1'b0; ext_align = 1'b0; base_wr = 1'b0; base_wdata = '0; kick = 1'b0;
        m_base = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!active && !mem_req && !tx_valid, "R1", "reset outputs",
            {29'd0, active, mem_req, tx_valid}, 32'h0);
        chk(!irq_txb && !irq_txf && !irq_babt && !tx_eof, "R1", "reset pulses",
            {28'd0, irq_txb, irq_txf, irq_babt, tx_eof}, 32'h0);
        mon_en  = 1'b1;
        ctrl_en = 1'b1;

        // R10 legacy alignment, R3 unaligned buffer, R5 two-part frame
        write_base(32'h0000_1003);
        set_desc(32'h1000, 5, 1, 0, 0, 32'h2001);
        set_desc(32'h1008, 6, 1, 0, 1, 32'h3000);
        set_desc(32'h1010, 3, 0, 0, 0, 32'h3100);
        run_walk("T1", 0);

        // R8 resume where the last walk stopped, R7 wrap back to base
        set_desc(32'h1010, 3, 1, 0, 1, 32'h3103);
        set_desc(32'h1018, 2, 1, 1, 1, 32'h3202);
        run_walk("T2", 0);

        set_desc(32'h1000, 1, 1, 0, 1, 32'h2400);
        run_walk("T3", 0);

        // R9 ignored kick, R8 reload on disable
        disabled_kick();
        set_desc(32'h1000, 7, 1, 0, 1, 32'h2005);
        run_walk("T4", 0);

        // R10 extended alignment, R4 truncation with zero allowance
        ext_align = 1'b1;
        write_base(32'h0000_4006);
        set_desc(32'h4000, 40, 1, 0, 0, 32'h5000);
        set_desc(32'h4008, 40, 1, 0, 1, 32'h6000);
        set_desc(32'h4010, 10, 1, 0, 1, 32'h6100);
        set_desc(32'h4018, 64, 1, 0, 0, 32'h7000);
        set_desc(32'h4020, 5,  1, 0, 0, 32'h7100);
        set_desc(32'h4028, 0,  1, 1, 1, 32'h7200);
        run_walk("T5", 0);

        // R2 cap per activation, R9 kick mid-walk
        write_base(32'h0001_0000);
        for (int i = 0; i < 1030; i++) set_desc(32'h10000 + 8 * i, 0, 1, 0, 0, 32'h0);
        set_desc(32'h10000 + 8 * 1030, 0, 0, 0, 0, 32'h0);
        run_walk("T6", 1);
        run_walk("T7", 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule